// File: doc/BRIEF.md
# LCD Vertical Frame Timing Generator

This block produces the vertical timing of a raster LCD panel. It receives a one-cycle strobe at the end of each line-clock period and counts those strobes through a frame. The frame consists of a programmed number of display lines, then an optional number of end-of-frame line waitstates, then a closing interval whose length is set by a 6-bit sync-width field. The block then returns to the start of the next frame. The same down counter times the closing interval in both modes. Only its meaning changes.

In active-matrix mode, the closing interval is the vertical sync pulse. The frame clock pin is held active for its whole length, and the line-clock gate enable is held low so that the line clock stops. In passive-matrix mode, the closing interval is made of dummy line periods. They give the fetch and dither pipeline time to refill before the next frame. The line clock keeps running, and the frame clock is active only for the first line period of the interval. In both modes, the first cycle of a frame-clock assertion also produces a flush strobe that discards over-read data from the input FIFO.

The configuration fields are captured in the one-cycle frame-start state, so software may rewrite them at any time. The lines field holds the panel height minus one. In dual-panel operation it holds half of the total display height. The block has no data stream, so every pin is a plain control or status signal with no valid/ready handshake and no back-pressure.

Top module: `lcd_vtiming`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, the frame clock pin is at its inactive level, fifo_flush is 0, lclk_en is 1 and frame_start is 1.
- R2: After frame start, the frame occupies exactly cfg_lines_m1+1 line_tick strobes of line counting (1 to 1024 lines).
- R3: After the last line, exactly cfg_eol_wait line_tick strobes of waitstates pass before the closing interval begins. A value of 0 starts the closing interval on the tick that ends the last line.
- R4: In active mode (cfg_active=1), the frame clock is active from the first cycle of the closing interval until the line_tick that completes cfg_sync_m1+1 line periods, so the pulse spans 1 to 64 line periods.
- R5: In active mode, lclk_en is 0 for the whole closing interval and 1 at all other times.
- R6: In passive mode (cfg_active=0), the closing interval lasts cfg_sync_m1+1 line_tick strobes, lclk_en stays 1, and the frame clock is active only from the interval's first cycle up to its first line_tick.
- R7: frame_start is a one-cycle pulse in the cycle after the closing interval ends. A line_tick arriving in that cycle is not counted.
- R8: fifo_flush is a one-cycle pulse in the first cycle of every frame-clock assertion, once per frame.
- R9: The frame clock pin equals the active-high internal frame clock when cfg_fclk_low=0 and its inverse when cfg_fclk_low=1. The polarity bit takes effect at once.
- R10: cfg_lines_m1, cfg_sync_m1, cfg_eol_wait and cfg_active are sampled only in the frame_start cycle. A change made during a frame affects only the following frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_tick | input | 1 | One-cycle strobe marking the end of a line-clock period |
| cfg_lines_m1 | input | 10 | Lines per panel minus one |
| cfg_sync_m1 | input | 6 | Sync pulse width or dummy line count minus one |
| cfg_eol_wait | input | 8 | End-of-frame line waitstates |
| cfg_active | input | 1 | 1 = active-matrix mode, 0 = passive-matrix mode |
| cfg_fclk_low | input | 1 | 1 = frame clock pin is active low |
| frame_clk | output | 1 | Frame clock / vertical sync pin |
| lclk_en | output | 1 | Gate enable for the line clock |
| frame_start | output | 1 | Permit for the next frame to begin |
| fifo_flush | output | 1 | Flush strobe for the input FIFO |

## Verification
The line strobe is applied in several patterns: every cycle, at fixed gaps of two and four cycles, and at random spacing. These show whether counts are kept in ticks rather than in clock cycles. The extreme field values are tried: a single line, zero waitstates, a one-period closing interval, 64-period pulses and a 1024-line frame. These expose off-by-one errors at each counter boundary. Both modes and both polarities are run. Configuration is rewritten in the middle of frames to separate sampling at frame start from direct use of the inputs. A tick also lands in the frame-start cycle, which shows whether that tick is correctly ignored.

// File: rtl/lcd_vt_pkg.sv
package lcd_vt_pkg;
  typedef enum logic [2:0] {
    VT_START = 3'd0,
    VT_LINES = 3'd1,
    VT_EOLW  = 3'd2,
    VT_SYNC  = 3'd3,
    VT_DUMMY = 3'd4
  } vt_state_e;
endpackage

// File: rtl/lcd_vt_cfg_latch.sv
module lcd_vt_cfg_latch #(
  parameter int LINE_W = 10,
  parameter int SYNC_W = 6,
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LINE_W-1:0] lines_d,
  input  logic [SYNC_W-1:0] sync_d,
  input  logic [WAIT_W-1:0] eol_d,
  input  logic              active_d,
  output logic [LINE_W-1:0] lines_q,
  output logic [SYNC_W-1:0] sync_q,
  output logic [WAIT_W-1:0] eol_q,
  output logic              active_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lines_q  <= '0;
      sync_q   <= '0;
      eol_q    <= '0;
      active_q <= 1'b0;
    end else if (load) begin
      lines_q  <= lines_d;
      sync_q   <= sync_d;
      eol_q    <= eol_d;
      active_q <= active_d;
    end
  end

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(lines_q) && $stable(sync_q) && $stable(eol_q) && $stable(active_q));
endmodule

// File: rtl/lcd_vt_upcnt.sv
module lcd_vt_upcnt #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (inc) q <= q + 1'b1;
  end
endmodule

// File: rtl/lcd_vt_dncnt.sv
module lcd_vt_dncnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] q,
  output logic         zero
);
  always_ff @(posedge clk) begin
    if (!rst_n)              q <= '0;
    else if (load)           q <= load_val;
    else if (dec && q != '0) q <= q - 1'b1;
  end

  assign zero = (q == '0);

  // R4
  dn_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q == $past(load_val));
endmodule

// File: rtl/lcd_vt_seq.sv
module lcd_vt_seq
  import lcd_vt_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [LINE_W-1:0] lines_q,
  input  logic [WAIT_W-1:0] eol_q,
  input  logic              active_q,
  input  logic              close_done,
  output vt_state_e         state,
  output logic              close_go
);
  logic [LINE_W-1:0] line_cnt;
  logic [WAIT_W-1:0] wait_cnt;
  logic              line_last;
  logic              wait_last;
  logic              line_inc;
  logic              wait_inc;
  vt_state_e         nxt;

  assign line_last = (line_cnt == lines_q);
  assign wait_last = ({1'b0, wait_cnt} + 1'b1) == {1'b0, eol_q};
  assign line_inc  = (state == VT_LINES) && tick && !line_last;
  assign wait_inc  = (state == VT_EOLW) && tick && !wait_last;

  lcd_vt_upcnt #(.W(LINE_W)) u_line_cnt (
    .clk(clk), .rst_n(rst_n), .clr(state == VT_START), .inc(line_inc), .q(line_cnt)
  );

  lcd_vt_upcnt #(.W(WAIT_W)) u_wait_cnt (
    .clk(clk), .rst_n(rst_n), .clr(state != VT_EOLW), .inc(wait_inc), .q(wait_cnt)
  );

  always_comb begin
    nxt      = state;
    close_go = 1'b0;
    unique case (state)
      VT_START: nxt = VT_LINES;
      VT_LINES: if (tick && line_last) begin
        if (eol_q == '0) begin
          close_go = 1'b1;
          nxt      = active_q ? VT_SYNC : VT_DUMMY;
        end else begin
          nxt = VT_EOLW;
        end
      end
      VT_EOLW: if (tick && wait_last) begin
        close_go = 1'b1;
        nxt      = active_q ? VT_SYNC : VT_DUMMY;
      end
      VT_SYNC, VT_DUMMY: if (tick && close_done) nxt = VT_START;
      default: nxt = VT_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= VT_START;
    else        state <= nxt;
  end

  // R2
  line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == VT_LINES) |-> (line_cnt <= lines_q));
  // R7
  start_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == VT_START) |=> (state == VT_LINES));
  // R3
  wait_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == VT_EOLW) |-> (wait_cnt < eol_q));
endmodule

// File: rtl/lcd_vtiming.sv
module lcd_vtiming
  import lcd_vt_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int SYNC_W = 6,
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_tick,
  input  logic [LINE_W-1:0] cfg_lines_m1,
  input  logic [SYNC_W-1:0] cfg_sync_m1,
  input  logic [WAIT_W-1:0] cfg_eol_wait,
  input  logic              cfg_active,
  input  logic              cfg_fclk_low,
  output logic              frame_clk,
  output logic              lclk_en,
  output logic              frame_start,
  output logic              fifo_flush
);
  logic [LINE_W-1:0] lines_q;
  logic [SYNC_W-1:0] sync_q;
  logic [WAIT_W-1:0] eol_q;
  logic              active_q;
  vt_state_e         state;
  logic              close_go;
  logic [SYNC_W-1:0] dn_q;
  logic              dn_zero;
  logic              fclk_int;
  logic              in_close;
  logic              flush_q;

  lcd_vt_cfg_latch #(.LINE_W(LINE_W), .SYNC_W(SYNC_W), .WAIT_W(WAIT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(state == VT_START),
    .lines_d(cfg_lines_m1), .sync_d(cfg_sync_m1), .eol_d(cfg_eol_wait), .active_d(cfg_active),
    .lines_q(lines_q), .sync_q(sync_q), .eol_q(eol_q), .active_q(active_q)
  );

  lcd_vt_seq #(.LINE_W(LINE_W), .WAIT_W(WAIT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(line_tick),
    .lines_q(lines_q), .eol_q(eol_q), .active_q(active_q),
    .close_done(dn_zero), .state(state), .close_go(close_go)
  );

  assign in_close = (state == VT_SYNC) || (state == VT_DUMMY);

  lcd_vt_dncnt #(.W(SYNC_W)) u_dn (
    .clk(clk), .rst_n(rst_n), .load(close_go), .load_val(sync_q),
    .dec(in_close && line_tick), .q(dn_q), .zero(dn_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) flush_q <= 1'b0;
    else        flush_q <= close_go;
  end

  assign fclk_int    = (state == VT_SYNC) || ((state == VT_DUMMY) && (dn_q == sync_q));
  assign frame_clk   = fclk_int ^ cfg_fclk_low;
  assign lclk_en     = (state != VT_SYNC);
  assign frame_start = (state == VT_START);
  assign fifo_flush  = flush_q;

  // R8
  flush_fclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> fclk_int);
  // R8
  flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |=> !fifo_flush);
  // R6
  passive_lclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == VT_DUMMY) |-> lclk_en);
  // R4
  sync_rise_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fclk_int) |-> fifo_flush);
endmodule

// File: tb/test_lcd_vtiming.sv
module test_lcd_vtiming;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       line_tick;
  logic [9:0] cfg_lines_m1;
  logic [5:0] cfg_sync_m1;
  logic [7:0] cfg_eol_wait;
  logic       cfg_active;
  logic       cfg_fclk_low;
  logic       frame_clk, lclk_en, frame_start, fifo_flush;

  int vectors = 0;
  int errors  = 0;
  bit wd_hit  = 1'b0;

  // reference model state
  int m_ph, m_seen, m_waits, m_end_ticks, m_end_cyc;
  int mL, mS, mE;
  bit mA;
  int post_rst;

  always #5 clk = ~clk;

  lcd_vtiming i_lcd_vtiming (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick),
    .cfg_lines_m1(cfg_lines_m1), .cfg_sync_m1(cfg_sync_m1), .cfg_eol_wait(cfg_eol_wait),
    .cfg_active(cfg_active), .cfg_fclk_low(cfg_fclk_low),
    .frame_clk(frame_clk), .lclk_en(lclk_en), .frame_start(frame_start), .fifo_flush(fifo_flush)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_seen = 0; m_waits = 0; m_end_ticks = 0; m_end_cyc = 0;
      mL = 0; mS = 0; mE = 0; mA = 1'b0;
      post_rst = 0;
    end else begin
      post_rst = post_rst + 1;
      case (m_ph)
        0: begin // frame start samples config (R10), tick ignored (R7)
          mL = cfg_lines_m1; mS = cfg_sync_m1; mE = cfg_eol_wait; mA = cfg_active;
          m_ph = 1; m_seen = 0;
        end
        1: if (line_tick) begin
          m_seen = m_seen + 1;
          if (m_seen == mL + 1) begin
            if (mE == 0) begin m_ph = 3; m_end_ticks = 0; m_end_cyc = 0; end
            else begin m_ph = 2; m_waits = 0; end
          end
        end
        2: if (line_tick) begin
          m_waits = m_waits + 1;
          if (m_waits == mE) begin m_ph = 3; m_end_ticks = 0; m_end_cyc = 0; end
        end
        default: begin
          m_end_cyc = m_end_cyc + 1;
          if (line_tick) begin
            m_end_ticks = m_end_ticks + 1;
            if (m_end_ticks == mS + 1) m_ph = 0;
          end
        end
      endcase
    end
  end

  task automatic compare();
    bit e_fs, e_fi, e_pin, e_len, e_fl;
    string tag;
    e_fs  = (m_ph == 0);
    e_fi  = (m_ph == 3) && (mA || m_end_ticks == 0);
    e_pin = e_fi ^ cfg_fclk_low;
    e_len = !((m_ph == 3) && mA);
    e_fl  = (m_ph == 3) && (m_end_cyc == 0);
    tag   = (!rst_n || post_rst <= 1) ? "R1 " : "";
    vectors++;
    if (frame_start !== e_fs) begin
      errors++;
      $display("FAIL %sR7 R2 R3 R10 frame_start actual=%b expected=%b t=%0t", tag, frame_start, e_fs, $time);
    end
    if (frame_clk !== e_pin) begin
      errors++;
      $display("FAIL %s%s R9 frame_clk actual=%b expected=%b t=%0t", tag, mA ? "R4" : "R6",
               frame_clk, e_pin, $time);
    end
    if (lclk_en !== e_len) begin
      errors++;
      $display("FAIL %sR5 R6 lclk_en actual=%b expected=%b t=%0t", tag, lclk_en, e_len, $time);
    end
    if (fifo_flush !== e_fl) begin
      errors++;
      $display("FAIL %sR8 fifo_flush actual=%b expected=%b t=%0t", tag, fifo_flush, e_fl, $time);
    end
  endtask

  // gap < 0: random spacing; gap >= 0: tick every gap+1 cycles
  task automatic run(input bit act, input bit pol, input int lines, input int sync,
                     input int eol, input int gap, input int ncyc);
    cfg_active   = act;
    cfg_fclk_low = pol;
    cfg_lines_m1 = 10'(lines);
    cfg_sync_m1  = 6'(sync);
    cfg_eol_wait = 8'(eol);
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      compare();
      if (gap < 0) line_tick = ($urandom_range(0, 2) == 0);
      else         line_tick = ((c % (gap + 1)) == gap);
    end
  endtask

  initial begin
    rst_n = 1'b0; line_tick = 1'b0;
    cfg_lines_m1 = '0; cfg_sync_m1 = '0; cfg_eol_wait = '0;
    cfg_active = 1'b1; cfg_fclk_low = 1'b0;
    // R1: reset state checked during reset and after release
    repeat (3) begin @(negedge clk); compare(); end
    rst_n = 1'b1;
    // R2 R3 R4 R5 R8: active mode, tick every cycle
    run(1'b1, 1'b0, 5, 2, 3, 0, 120);
    // R9: inverted polarity, R10: config changed mid-frame
    run(1'b1, 1'b1, 3, 0, 0, 1, 150);
    // R6: passive mode with dummy lines and random tick spacing
    run(1'b0, 1'b0, 4, 5, 2, -1, 300);
    run(1'b0, 1'b1, 0, 0, 0, 0, 60);
    // R4: widest pulse, ticks every fifth cycle
    run(1'b1, 1'b0, 2, 63, 1, 4, 900);
    // R6: widest dummy interval
    run(1'b0, 1'b0, 1, 63, 0, 0, 300);
    // R2: 1024-line frame, R3: large waitstate count
    run(1'b1, 1'b0, 1023, 3, 255, 0, 2700);
    // R7: ticks every cycle so one lands in each frame-start cycle
    run(1'b0, 1'b1, 0, 1, 1, 0, 80);
    run(1'b1, 1'b0, 7, 4, 0, -1, 800);
    // R1: reset in the middle of a frame
    rst_n = 1'b0;
    repeat (2) begin @(negedge clk); compare(); end
    rst_n = 1'b1;
    run(1'b0, 1'b0, 2, 2, 2, 2, 200);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    wd_hit = 1'b1;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule